// File: doc/BRIEF.md
# Byte-Wide SPI Master Shift Engine

This block is an SPI master that moves one byte at a time. When the host writes a byte into the data buffer while the engine is idle, an 8-bit full-duplex transfer starts at once. There is no separate start command. The byte leaves on `sdo_o` with the most significant bit first. At the same time the byte arriving on `sdi_i` is shifted in. When the last half-bit ends, the received byte lands in the read buffer and a sticky completion flag rises.

The serial clock has a selectable idle level. It also has two launch phases:
- In the early-launch phase the first data bit is valid before any clock edge.
- In the late-launch phase data changes together with the leading clock edge.

An independent select bit places the input sample either at mid-bit or at the end of each bit. The bit rate comes from one of five sources:
- three fixed dividers of the system clock;
- an external timer tick, halved;
- a reload value `r`, giving a bit period of `4*(r+1)` clocks.

The rate source is captured when a transfer starts, and so are the polarity, phase and sample point. Writes that arrive while a transfer runs are dropped and reported. A completion that finds the previous byte still unacknowledged is also reported, and that new byte is discarded.

Top module: `spi_master_engine`

## Requirements
- R1: With `busy_o` low, a write (`wr_en_i` high for one cycle) starts a transfer. `busy_o` is high from the next cycle for exactly 16 half-bit intervals and falls in the same cycle that `done_o` rises.
- R2: `sdo_o` carries the written byte MSB first. Bit 7-k is valid from half-bit 2k through half-bit 2k+1, where half-bit 0 begins at the write. After the transfer `sdo_o` holds bit 0 until the next start.
- R3: While idle, `sck_o` equals `cpol_i` (0 = low idle, 1 = high idle). After the last half-bit it returns to that level.
- R4: When `early_i`=1, `sck_o` stays idle during half-bit 0 and toggles at every half-bit boundary from 1 to 16. When `early_i`=0, `sck_o` goes to its active level at the write and toggles at boundaries 1 to 15. In both phases the active level is the inverse of the idle level.
- R5: When `smp_end_i`=0, `sdi_i` is sampled at the odd half-bit boundaries 1,3,..,15 (mid-bit). When `smp_end_i`=1, it is sampled at the even boundaries 2,4,..,16 (end of bit). The first sample becomes bit 7 of the received byte.
- R6: `rate_sel_i` sets the half-bit length:
  - 0: 2 clocks
  - 1: 8 clocks
  - 2: 32 clocks
  - 3: one boundary per cycle in which `tmr_tick_i` is high
  - 4: 2*(`reload_i`+1) clocks
  - 5 to 7: 2 clocks
- R7: At the end of a transfer the received byte appears on `rd_data_o` and `done_o` is set. `done_o` stays set until `done_clr_i` is pulsed. `rd_data_o` changes only at a buffer load.
- R8: With `sdo_en_i`=0, `sdo_o` and `sdo_oe_o` are low. Reception, buffer load and `done_o` behave exactly as in a normal transfer.
- R9: A write while `busy_o` is high is ignored: the transfer in flight continues with its original byte. The write sets `wcol_o`, which stays high until `err_clr_i`.
- R10: If a transfer completes while `done_o` is still set and `done_clr_i` is low in that cycle, `ovf_o` is set (sticky until `err_clr_i`) and `rd_data_o` keeps its previous byte.
- R11: `rate_sel_i` and `reload_i` are captured at the write. Changing them during a transfer does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | DATA_W | Byte to transmit |
| rd_data_o | output | DATA_W | Received-byte buffer |
| done_clr_i | input | 1 | Clears the completion flag |
| err_clr_i | input | 1 | Clears the collision and overflow flags |
| cpol_i | input | 1 | Idle level of the serial clock |
| early_i | input | 1 | 1: data valid before the first clock edge |
| smp_end_i | input | 1 | 1: sample at end of bit, 0: at mid-bit |
| sdo_en_i | input | 1 | Serial output enable |
| rate_sel_i | input | 3 | Bit-rate source select |
| reload_i | input | RLD_W | Reload value of the programmable divider |
| tmr_tick_i | input | 1 | External timer tick |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| sdi_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |
| ovf_o | output | 1 | Receive-overflow flag |

## Verification
The bench builds the engine with its defaults: 8-bit data, an 8-bit reload field, and fixed dividers of 4, 16 and 64. The full reload range is therefore reachable. A directed transfer at reload 255 covers the longest half-bit of 512 clocks, and the reload-0 case gives the shortest half-bit of 2 clocks. The timer source is driven with tick periods down to one cycle, so a boundary can fall on every clock. Because the bench aligns its serial input pattern to every half-bit boundary, the mid-bit and end-of-bit sample choices produce different received bytes.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

  typedef enum logic [2:0] {
    RATE_D_A = 3'd0,
    RATE_D_B = 3'd1,
    RATE_D_C = 3'd2,
    RATE_TMR = 3'd3,
    RATE_RLD = 3'd4
  } rate_sel_e;

  typedef struct packed {
    logic early;
    logic smp_end;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_eng_rate.sv
`timescale 1ns/1ps
module spi_eng_rate #(
  parameter int RLD_W = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [2:0]       sel_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             strobe_o
);
  import spi_eng_pkg::*;

  localparam int CNT_W = RLD_W + 2;
  localparam logic [CNT_W-1:0] HALF_A = CNT_W'(DIV_A / 2);
  localparam logic [CNT_W-1:0] HALF_B = CNT_W'(DIV_B / 2);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DIV_C / 2);

  logic [CNT_W-1:0] half_d, half_q, cnt_q;
  logic             tmr_q;

  always_comb begin
    case (rate_sel_e'(sel_i))
      RATE_D_A: half_d = HALF_A;
      RATE_D_B: half_d = HALF_B;
      RATE_D_C: half_d = HALF_C;
      RATE_RLD: half_d = ({2'b00, reload_i} + CNT_W'(1)) << 1;
      default:  half_d = HALF_A;
    endcase
  end

  // source is frozen for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= 1'b0;
      half_q <= HALF_A;
      cnt_q  <= '0;
    end else if (start_i) begin
      tmr_q  <= (sel_i == RATE_TMR);
      half_q <= half_d;
      cnt_q  <= half_d - CNT_W'(1);
    end else if (run_i && !tmr_q) begin
      if (cnt_q == '0) cnt_q <= half_q - CNT_W'(1);
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign strobe_o = run_i & ~start_i & (tmr_q ? tick_i : (cnt_q == '0));

endmodule

// File: rtl/spi_eng_shift.sv
`timescale 1ns/1ps
module spi_eng_shift #(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  strobe_i,
  input  spi_eng_pkg::xfer_cfg_t cfg_i,
  input  logic [DATA_W-1:0]     tx_i,
  input  logic                  sdi_i,
  output logic                  act_o,
  output logic                  sdo_o,
  output logic                  busy_o,
  output logic                  last_o,
  output logic [DATA_W-1:0]     rx_o
);
  import spi_eng_pkg::*;

  localparam int HALVES = 2 * DATA_W;
  localparam int HC_W   = $clog2(HALVES + 1);

  xfer_cfg_t         cfg_q;
  logic              busy_q, act_q;
  logic [HC_W-1:0]   hcnt_q, hnext;
  logic [DATA_W-1:0] tx_q, rx_q, rx_shift;
  logic              step, sample;

  assign step     = strobe_i & busy_q;
  assign hnext    = hcnt_q + HC_W'(1);
  assign last_o   = step & (hnext == HC_W'(HALVES));
  // odd boundaries are mid-bit, even ones end-of-bit
  assign sample   = step & (hnext[0] ^ cfg_q.smp_end);
  assign rx_shift = {rx_q[DATA_W-2:0], sdi_i};
  assign rx_o     = cfg_q.smp_end ? rx_shift : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      hcnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      cfg_q  <= cfg_i;
      busy_q <= 1'b1;
      act_q  <= ~cfg_i.early;
      hcnt_q <= '0;
      tx_q   <= tx_i;
    end else if (step) begin
      hcnt_q <= hnext;
      if (sample) rx_q <= rx_shift;
      if (last_o) begin
        busy_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        act_q <= ~act_q;
        if (!hnext[0]) tx_q <= tx_q << 1;
      end
    end
  end

  assign act_o  = act_q;
  assign sdo_o  = tx_q[DATA_W-1];
  assign busy_o = busy_q;

endmodule

// File: rtl/spi_master_engine.sv
`timescale 1ns/1ps
module spi_master_engine #(
  parameter int DATA_W = 8,
  parameter int RLD_W  = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              done_clr_i,
  input  logic              err_clr_i,
  input  logic              cpol_i,
  input  logic              early_i,
  input  logic              smp_end_i,
  input  logic              sdo_en_i,
  input  logic [2:0]        rate_sel_i,
  input  logic [RLD_W-1:0]  reload_i,
  input  logic              tmr_tick_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wcol_o,
  output logic              ovf_o
);
  import spi_eng_pkg::*;

  logic              start, strobe, act, sdo_raw, busy, last;
  logic [DATA_W-1:0] rx;
  logic              pol_q, done_q, wcol_q, ovf_q, lost;
  logic [DATA_W-1:0] buf_q;
  xfer_cfg_t         cfg;

  assign start = wr_en_i & ~busy;
  assign cfg   = '{early: early_i, smp_end: smp_end_i};

  spi_eng_rate #(
    .RLD_W(RLD_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (busy),
    .sel_i    (rate_sel_i),
    .reload_i (reload_i),
    .tick_i   (tmr_tick_i),
    .strobe_o (strobe)
  );

  spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .strobe_i (strobe),
    .cfg_i    (cfg),
    .tx_i     (wr_data_i),
    .sdi_i    (sdi_i),
    .act_o    (act),
    .sdo_o    (sdo_raw),
    .busy_o   (busy),
    .last_o   (last),
    .rx_o     (rx)
  );

  // previous byte not acknowledged when the new one lands
  assign lost = last & done_q & ~done_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= 1'b0;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (start) pol_q <= cpol_i;
      if (last)            done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
      if (wr_en_i && busy) wcol_q <= 1'b1;
      else if (err_clr_i)  wcol_q <= 1'b0;
      if (lost)            ovf_q <= 1'b1;
      else if (err_clr_i)  ovf_q <= 1'b0;
      if (last && !lost)   buf_q <= rx;
    end
  end

  assign sck_o     = act ^ (busy ? pol_q : cpol_i);
  assign sdo_o     = sdo_en_i & sdo_raw;
  assign sdo_oe_o  = sdo_en_i;
  assign busy_o    = busy;
  assign done_o    = done_q;
  assign wcol_o    = wcol_q;
  assign ovf_o     = ovf_q;
  assign rd_data_o = buf_q;

endmodule

// File: rtl/spi_master_engine_chk.sv
`timescale 1ns/1ps
module spi_master_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              cpol_i,
  input logic              sdo_en_i,
  input logic              done_clr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              wcol_o,
  input logic              ovf_o,
  input logic              sck_o,
  input logic              sdo_o,
  input logic [DATA_W-1:0] rd_data_o
);

  p_busy_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i));

  p_done_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));

  p_buf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(rd_data_o));

  p_idle_sck_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cpol_i));

  p_sdo_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && sdo_en_i && $past(sdo_en_i)) |-> $stable(sdo_o));

  p_wcol_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_o) |=> wcol_o);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(done_o) && !$past(done_clr_i)) |-> ovf_o);

endmodule

bind spi_master_engine spi_master_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_master_engine_bench.sv
`timescale 1ns/1ps
module spi_master_engine_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       done_clr_i = 1'b0, err_clr_i = 1'b0;
  logic       cpol_i = 1'b0, early_i = 1'b1, smp_end_i = 1'b0, sdo_en_i = 1'b1;
  logic [2:0] rate_sel_i = '0;
  logic [7:0] reload_i = '0;
  logic       tmr_tick_i = 1'b0, sdi_i = 1'b0;
  logic       sck_o, sdo_o, sdo_oe_o, busy_o, done_o, wcol_o, ovf_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_buf = '0;
  bit exp_ovf = 1'b0, exp_wcol = 1'b0;

  always #2 clk_i = ~clk_i;

  spi_master_engine #(.DATA_W(8), .RLD_W(8), .DIV_A(4), .DIV_B(16), .DIV_C(64)) u_spi_master_engine (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .done_clr_i, .err_clr_i,
    .cpol_i, .early_i, .smp_end_i, .sdo_en_i, .rate_sel_i, .reload_i, .tmr_tick_i,
    .sck_o, .sdo_o, .sdo_oe_o, .sdi_i, .busy_o, .done_o, .wcol_o, .ovf_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int half_len(input int sel, input int rld, input int tper);
    case (sel)
      0: return 2;
      1: return 8;
      2: return 32;
      3: return tper;
      4: return 2 * (rld + 1);
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_rx(input logic [15:0] pat, input bit smp);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = pat[2*k + smp];
    return r;
  endfunction

  task automatic pulse_done_clr();
    done_clr_i = 1'b1; @(posedge clk_i); @(negedge clk_i); done_clr_i = 1'b0;
  endtask

  task automatic pulse_err_clr();
    err_clr_i = 1'b1; @(posedge clk_i); @(negedge clk_i); err_clr_i = 1'b0;
    exp_wcol = 0; exp_ovf = 0;
  endtask

  // runs one transfer, bench acting as the slave on sdi_i
  task automatic xfer(input logic [7:0] tx, input logic [15:0] pat, input int sel,
                      input int rld, input int tper, input bit pol, input bit early,
                      input bit smp, input bit oen, input bit mess, input bit wc);
    int h; bit pend; bit sck_ok = 1, sdo_ok = 1, busy_ok = 1, wv_bad = 0;
    logic [7:0] rx;
    h = half_len(sel, rld, tper);
    rx = exp_rx(pat, smp);
    pend = done_o;
    cpol_i = pol; early_i = early; smp_end_i = smp; sdo_en_i = oen;
    rate_sel_i = 3'(sel); reload_i = 8'(rld);
    wr_data_i = tx; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
    for (int c = 0; c < 16 * h; c++) begin
      int n; bit act; logic exp_sck, exp_sdo;
      n = c / h;
      act = early ? n[0] : ~n[0];
      exp_sck = pol ^ act;
      exp_sdo = oen ? tx[7 - n/2] : 1'b0;
      if (c == 0) begin
        chk(sck_o == exp_sck, "R4 first edge placement", sck_o, exp_sck);
        chk(sdo_o == exp_sdo, "R4 first bit at write", sdo_o, exp_sdo);
      end
      if (sck_o !== exp_sck) begin
        if (sck_ok) $display("FAIL R3/R4 sck at c=%0d actual=%0h expected=%0h", c, sck_o, exp_sck);
        sck_ok = 0; wv_bad = 1;
      end
      if (sdo_o !== exp_sdo) begin
        if (sdo_ok) $display("FAIL R2 sdo at c=%0d actual=%0h expected=%0h", c, sdo_o, exp_sdo);
        sdo_ok = 0; wv_bad = 1;
      end
      if (busy_o !== 1'b1) busy_ok = 0;
      sdi_i = pat[n];
      tmr_tick_i = ((c + 1) % h == 0);
      if (mess && c == 1) begin rate_sel_i = 3'($urandom_range(0, 7)); reload_i = 8'($urandom); end
      if (wc && c == 3) begin wr_en_i = 1'b1; wr_data_i = ~tx; end
      if (wc && c == 4) wr_en_i = 1'b0;
      @(posedge clk_i); @(negedge clk_i);
    end
    tmr_tick_i = 1'b0;
    wr_en_i = 1'b0;
    // waveform failures already printed once above
    n_chk++; if (wv_bad) n_bad++;
    chk(busy_ok, "R1/R6/R11 busy length", busy_ok, 1);
    chk(busy_o == 1'b0 && done_o == 1'b1, "R1/R7 busy falls with done", {busy_o, done_o}, 2'b01);
    if (!pend) exp_buf = rx; else exp_ovf = 1;
    if (wc) exp_wcol = 1;
    chk(rd_data_o == exp_buf, "R5/R7/R10 buffer", rd_data_o, exp_buf);
    chk(ovf_o == exp_ovf, "R10 overflow flag", ovf_o, exp_ovf);
    chk(wcol_o == exp_wcol, "R9 collision flag", wcol_o, exp_wcol);
    chk(sck_o == pol, "R3 sck back to idle", sck_o, pol);
    chk(sdo_o == (oen & tx[0]) && sdo_oe_o == oen, "R2/R8 sdo after", {sdo_oe_o, sdo_o}, {oen, oen & tx[0]});
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && wcol_o == 0 && ovf_o == 0, "R1 reset flags",
        {busy_o, done_o, wcol_o, ovf_o}, 0);
    chk(rd_data_o == 0 && sdo_o == 0, "R7 reset buffer", rd_data_o, 0);
    chk(sck_o == 1'b0, "R3 reset sck", sck_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cpol_i = 1'b1; @(negedge clk_i);
    chk(sck_o == 1'b1, "R3 idle follows polarity", sck_o, 1);

    // directed corners
    xfer(8'hA5, 16'hC3A9, 0, 0, 1, 0, 1, 0, 1, 0, 0);  pulse_done_clr();
    xfer(8'h3C, 16'h5A0F, 1, 0, 1, 1, 0, 1, 1, 0, 0);  pulse_done_clr();
    xfer(8'h81, 16'h9C63, 3, 0, 3, 0, 0, 0, 1, 0, 0);  pulse_done_clr();
    xfer(8'h7E, 16'hF00F, 3, 0, 1, 1, 1, 1, 1, 0, 0);  pulse_done_clr();
    xfer(8'h96, 16'h1234, 4, 0, 1, 0, 1, 1, 1, 0, 0);  pulse_done_clr();
    xfer(8'h69, 16'hBEEF, 4, 255, 1, 1, 1, 0, 1, 1, 0); pulse_done_clr();
    xfer(8'h0F, 16'hCAFE, 6, 0, 1, 0, 0, 1, 1, 0, 0);  pulse_done_clr();
    xfer(8'hC3, 16'h2DB4, 2, 0, 1, 0, 1, 0, 1, 1, 0);  pulse_done_clr();
    // R8 receive only
    xfer(8'hFF, 16'h6B29, 0, 0, 1, 1, 1, 1, 0, 0, 0);
    chk(done_o == 1, "R8 done in receive-only", done_o, 1);
    pulse_done_clr();
    // R9 collision
    xfer(8'h55, 16'h0FF0, 1, 0, 1, 0, 1, 0, 1, 0, 1);  pulse_done_clr();
    pulse_err_clr();
    chk(wcol_o == 0, "R9 collision cleared", wcol_o, 0);
    // R7 done sticky then cleared
    repeat (5) @(negedge clk_i);
    xfer(8'h12, 16'hA1B2, 0, 0, 1, 0, 1, 1, 1, 0, 0);
    repeat (7) @(negedge clk_i);
    chk(done_o == 1, "R7 done sticky", done_o, 1);
    // R10 overflow: no clear before next byte
    xfer(8'h34, 16'h7711, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    pulse_done_clr();
    chk(done_o == 0, "R7 done cleared", done_o, 0);
    pulse_err_clr();
    chk(ovf_o == 0, "R10 overflow cleared", ovf_o, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int sel, rld, tp;
      sel = $urandom_range(0, 7);
      rld = $urandom_range(0, 15);
      tp  = $urandom_range(1, 6);
      xfer(8'($urandom), 16'($urandom), sel, rld, tp, 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom_range(0, 4) != 0), 1'($urandom), ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 3) != 0) pulse_done_clr();
      if (exp_wcol || exp_ovf) pulse_err_clr();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule